// File: doc/BRIEF.md
# Zoned Bus Bandwidth Monitor

This block watches the transfers on one bus port and measures how much data passes in each sampling window. Every accepted transfer adds its byte count to a window accumulator. The accumulated bytes are read as a count in a fixed unit of a power-of-two number of bytes, and the count saturates at 12 bits. The window length is given in ticks of a slow reference clock, which reaches the block as a one-cycle strobe in the block's own clock domain.

When a window closes, the block puts the window count into one of four zones using three programmable thresholds. Each zone has an action byte. That byte can bump or clear the hit counter of any zone. A zone raises its interrupt status bit once its hit counter reaches a programmable limit. The block also keeps the largest count it has seen in each zone. A 32-bit register port configures the block and reads it back. A single level interrupt output reports the enabled status bits. Software reads the zone maxima and moves the thresholds to follow the traffic.

Top module: `bw_zone_monitor`

## Requirements
- R1: A window closes on the reference tick at which the tick count since the last close reaches the programmed length. For example, with length 4, it closes on the fourth tick. A length of 0 never closes a window. The length register is at 0x08.
- R2: The window count is the accumulated bytes divided by UNIT_BYTES, rounded down, and it saturates at 0xFFF.
- R3: The thresholds low, mid and high are at 0x0C, 0x10 and 0x14. A closed window falls in zone 0 when the count is below low, in zone 1 when it is below mid, in zone 2 when it is below high, and in zone 3 otherwise. A count equal to a threshold therefore falls in the upper zone.
- R4: The action register at 0x18 holds one byte per source zone, with zone z at bits 8z+7:8z. Inside that byte, bits 2t+1:2t act on the hit counter of zone t. Code 2 increments the counter, saturating at 255. Code 1 clears it. Codes 0 and 3 leave it unchanged. Only the byte of the zone just entered applies.
- R5: The limit register at 0x1C is packed in the same way as the action register. Status bit t (register 0x20, bits 3:0) sets at a window close when hit counter t is incremented and reaches its limit. A limit of 0xFF never sets the bit.
- R6: Zone maximum z, at 0x30+4z, takes the count of a window that closed in zone z if that count is larger than the value it holds. Otherwise it never decreases.
- R7: Writing ones to 0x24 clears the matching status bits. The irq output is high when any status bit is set together with its enable bit in 0x28, bits 3:0. A status bit still latches while its enable bit is 0.
- R8: Register 0x04 is a restart register. Writing it with bit 0 or bit 1 set restarts the window: the tick count and the accumulator go to zero, and any close in that same cycle is cancelled. Bit 1 also zeroes all hit counters and zone maxima.
- R9: Bit 0 of 0x00 enables monitoring. While it is 0, transfers are not accumulated, ticks do not advance the window, and no status bit sets.
- R10: A transfer in the same cycle as a window close counts toward the next window.
- R11: After reset every register reads 0 except the limit register, which reads 0xFFFFFFFF. The write-only registers 0x04 and 0x24, and any unmapped address, read 0. Register writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | One-cycle strobe per reference clock tick |
| xfer_valid | input | 1 | A transfer is seen on the monitored port this cycle |
| xfer_bytes | input | BYTES_W | Bytes moved by that transfer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt, level |

## Verification
The assertions assume that the reference tick and the transfer strobe are single-cycle pulses in the block clock domain. They also assume that UNIT_BYTES is a power of two and that one transfer never carries more bytes than the accumulator can hold, so saturation happens only across several transfers. The stimulus keeps to this. Ticks are driven as plain strobes. Transfers stay at or below 65472 bytes with a unit of 64 bytes. Saturation is reached only by stacking several large transfers inside one window. Window lengths are changed only while the window is idle or while its length is 0, so the closing tick is never ambiguous.

// File: rtl/bwz_pkg.sv
// Shared constants for the zoned bandwidth monitor: register map, zone
// count, per-zone field width and the hit-counter action codes.
package bwz_pkg;
    localparam int NUM_ZONES = 4;
    localparam int FIELD_W   = 8;

    localparam logic [7:0] A_CTRL     = 8'h00;
    localparam logic [7:0] A_RESTART  = 8'h04;
    localparam logic [7:0] A_WINLEN   = 8'h08;
    localparam logic [7:0] A_THR_LO   = 8'h0C;
    localparam logic [7:0] A_THR_MID  = 8'h10;
    localparam logic [7:0] A_THR_HI   = 8'h14;
    localparam logic [7:0] A_ACTION   = 8'h18;
    localparam logic [7:0] A_LIMIT    = 8'h1C;
    localparam logic [7:0] A_STATUS   = 8'h20;
    localparam logic [7:0] A_ACK      = 8'h24;
    localparam logic [7:0] A_IRQEN    = 8'h28;
    localparam logic [7:0] A_MAX_BASE = 8'h30;

    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_BUMP  = 2'd2,
        ACT_RSVD  = 2'd3
    } hit_action_e;

    typedef logic [1:0] zone_idx_t;
endpackage

// File: rtl/bwz_window.sv
// Window timer and byte accumulator.
// Counts reference ticks while enabled and flags the cycle in which a window
// closes. Accumulates transfer bytes with saturation and presents the count
// in units of 2**UNIT_SH bytes.
// Assumes: UNIT_SH + CNT_W >= BYTES_W; restart has priority over a close.
module bwz_window #(
    parameter int WIN_W   = 24,
    parameter int BYTES_W = 16,
    parameter int CNT_W   = 12,
    parameter int UNIT_SH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               ref_tick,
    input  logic [WIN_W-1:0]   win_len,
    input  logic               xfer_valid,
    input  logic [BYTES_W-1:0] xfer_bytes,
    input  logic               restart,
    output logic               boundary,
    output logic [CNT_W-1:0]   win_count
);
    localparam int ACC_W = CNT_W + UNIT_SH;

    logic [WIN_W-1:0] tick_cnt;
    logic [WIN_W:0]   tick_next;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] add_ext;
    logic [ACC_W:0]   acc_sum;
    logic [ACC_W-1:0] acc_sat;
    logic             tick_go;

    // Decide whether this tick closes the window.
    always_comb begin
        tick_go   = enable & ref_tick;
        tick_next = {1'b0, tick_cnt} + {{WIN_W{1'b0}}, 1'b1};
        boundary  = tick_go & (win_len != '0) & ~restart
                  & (tick_next >= {1'b0, win_len});
    end

    // Form the saturating sum of the accumulator and this cycle's bytes.
    always_comb begin
        add_ext = (enable & xfer_valid)
                ? {{(ACC_W-BYTES_W){1'b0}}, xfer_bytes} : '0;
        acc_sum = {1'b0, acc} + {1'b0, add_ext};
        acc_sat = acc_sum[ACC_W] ? {ACC_W{1'b1}} : acc_sum[ACC_W-1:0];
    end

    assign win_count = acc[ACC_W-1 -: CNT_W];

    // Advance the tick counter and accumulator; restart wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick_cnt <= '0;
            acc      <= '0;
        end else if (boundary) begin
            tick_cnt <= '0;
            acc      <= add_ext;
        end else begin
            if (tick_go) begin
                tick_cnt <= tick_next[WIN_W-1:0];
            end
            acc <= acc_sat;
        end
    end
endmodule

// File: rtl/bwz_zone_engine.sv
// Zone classifier and per-zone bookkeeping.
// At a window close: picks the zone, applies that zone's action byte to every
// hit counter, raises status where a bumped counter meets its limit, and
// updates the zone maximum. Status bits are write-one-to-clear; a set in the
// same cycle as a clear is kept.
// Assumes: clear_all is only asserted together with a cancelled close.
module bwz_zone_engine
    import bwz_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          boundary,
    input  logic [CNT_W-1:0]              win_count,
    input  logic [CNT_W-1:0]              thr_lo,
    input  logic [CNT_W-1:0]              thr_mid,
    input  logic [CNT_W-1:0]              thr_hi,
    input  logic [NUM_ZONES*FIELD_W-1:0]  actions,
    input  logic [NUM_ZONES*FIELD_W-1:0]  limits,
    input  logic                          clear_all,
    input  logic [NUM_ZONES-1:0]          ack_mask,
    output logic [NUM_ZONES-1:0]          status,
    output logic [NUM_ZONES*CNT_W-1:0]    zone_max
);
    localparam logic [FIELD_W-1:0] HIT_TOP = {FIELD_W{1'b1}};

    zone_idx_t          cur_zone;
    logic [FIELD_W-1:0] act_sel;

    // Classify the closing window; equality falls into the upper zone.
    always_comb begin
        if (win_count < thr_lo)       cur_zone = 2'd0;
        else if (win_count < thr_mid) cur_zone = 2'd1;
        else if (win_count < thr_hi)  cur_zone = 2'd2;
        else                          cur_zone = 2'd3;
        act_sel = actions[cur_zone*FIELD_W +: FIELD_W];
    end

    for (genvar t = 0; t < NUM_ZONES; t++) begin : g_zone
        hit_action_e        code;
        logic               bump;
        logic               wipe;
        logic               fire;
        logic [FIELD_W-1:0] hit_q;
        logic [FIELD_W-1:0] hit_d;
        logic [FIELD_W-1:0] lim;
        logic [CNT_W-1:0]   max_q;

        // Work out the next hit count and whether the limit is met.
        always_comb begin
            code  = hit_action_e'(act_sel[2*t +: 2]);
            bump  = boundary & (code == ACT_BUMP);
            wipe  = boundary & (code == ACT_CLEAR);
            lim   = limits[t*FIELD_W +: FIELD_W];
            if (bump)      hit_d = (hit_q == HIT_TOP) ? hit_q : hit_q + 1'b1;
            else if (wipe) hit_d = '0;
            else           hit_d = hit_q;
            fire  = bump & (lim != HIT_TOP) & (hit_d >= lim);
        end

        // Hold the hit counter of this zone.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) hit_q <= '0;
            else                     hit_q <= hit_d;
        end

        // Latch the status bit; a new event outranks an acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) status[t] <= 1'b0;
            else        status[t] <= fire | (status[t] & ~ack_mask[t]);
        end

        // Track the largest count seen in this zone.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                max_q <= '0;
            end else if (boundary && (cur_zone == zone_idx_t'(t))
                         && (win_count > max_q)) begin
                max_q <= win_count;
            end
        end

        assign zone_max[t*CNT_W +: CNT_W] = max_q;
    end
endmodule

// File: rtl/bwz_regs.sv
// Register file and read mux.
// Holds configuration, decodes the write-only restart and acknowledge
// registers into one-cycle strobes, and returns read data combinationally.
// Assumes: aligned 32-bit accesses; unmapped and write-only addresses read 0.
module bwz_regs
    import bwz_pkg::*;
#(
    parameter int WIN_W = 24,
    parameter int CNT_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [7:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic [NUM_ZONES-1:0]         status,
    input  logic [NUM_ZONES*CNT_W-1:0]   zone_max,
    output logic                         ctrl_en,
    output logic [WIN_W-1:0]             win_len,
    output logic [CNT_W-1:0]             thr_lo,
    output logic [CNT_W-1:0]             thr_mid,
    output logic [CNT_W-1:0]             thr_hi,
    output logic [NUM_ZONES*FIELD_W-1:0] actions,
    output logic [NUM_ZONES*FIELD_W-1:0] limits,
    output logic [NUM_ZONES-1:0]         irq_en,
    output logic                         restart,
    output logic                         clear_all,
    output logic [NUM_ZONES-1:0]         ack_mask
);
    logic hit_restart;
    logic hit_ack;

    // Decode the strobe registers.
    always_comb begin
        hit_restart = reg_we & (reg_addr == A_RESTART);
        hit_ack     = reg_we & (reg_addr == A_ACK);
        restart     = hit_restart & (reg_wdata[0] | reg_wdata[1]);
        clear_all   = hit_restart & reg_wdata[1];
        ack_mask    = hit_ack ? reg_wdata[NUM_ZONES-1:0] : '0;
    end

    // Store the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            win_len <= '0;
            thr_lo  <= '0;
            thr_mid <= '0;
            thr_hi  <= '0;
            actions <= '0;
            limits  <= '1;
            irq_en  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL:    ctrl_en <= reg_wdata[0];
                A_WINLEN:  win_len <= reg_wdata[WIN_W-1:0];
                A_THR_LO:  thr_lo  <= reg_wdata[CNT_W-1:0];
                A_THR_MID: thr_mid <= reg_wdata[CNT_W-1:0];
                A_THR_HI:  thr_hi  <= reg_wdata[CNT_W-1:0];
                A_ACTION:  actions <= reg_wdata[NUM_ZONES*FIELD_W-1:0];
                A_LIMIT:   limits  <= reg_wdata[NUM_ZONES*FIELD_W-1:0];
                A_IRQEN:   irq_en  <= reg_wdata[NUM_ZONES-1:0];
                default:   ;
            endcase
        end
    end

    // Return read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:    reg_rdata = {31'd0, ctrl_en};
            A_WINLEN:  reg_rdata = {{(32-WIN_W){1'b0}}, win_len};
            A_THR_LO:  reg_rdata = {{(32-CNT_W){1'b0}}, thr_lo};
            A_THR_MID: reg_rdata = {{(32-CNT_W){1'b0}}, thr_mid};
            A_THR_HI:  reg_rdata = {{(32-CNT_W){1'b0}}, thr_hi};
            A_ACTION:  reg_rdata = actions;
            A_LIMIT:   reg_rdata = limits;
            A_STATUS:  reg_rdata = {{(32-NUM_ZONES){1'b0}}, status};
            A_IRQEN:   reg_rdata = {{(32-NUM_ZONES){1'b0}}, irq_en};
            default: begin
                for (int z = 0; z < NUM_ZONES; z++) begin
                    if (reg_addr == A_MAX_BASE + 8'(4*z)) begin
                        reg_rdata = {{(32-CNT_W){1'b0}}, zone_max[z*CNT_W +: CNT_W]};
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/bw_zone_monitor.sv
// Top of the zoned bandwidth monitor.
// Wires the register file, window timer/accumulator and zone engine, and
// drives the interrupt from enabled status bits.
// Assumes: UNIT_BYTES is a power of two and covers BYTES_W with the count.
module bw_zone_monitor
    import bwz_pkg::*;
#(
    parameter int WIN_W      = 24,
    parameter int BYTES_W    = 16,
    parameter int UNIT_BYTES = 65536,
    parameter int CNT_W      = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               xfer_valid,
    input  logic [BYTES_W-1:0] xfer_bytes,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    localparam int UNIT_SH = $clog2(UNIT_BYTES);

    logic                         ctrl_en;
    logic [WIN_W-1:0]             win_len;
    logic [CNT_W-1:0]             thr_lo;
    logic [CNT_W-1:0]             thr_mid;
    logic [CNT_W-1:0]             thr_hi;
    logic [NUM_ZONES*FIELD_W-1:0] actions;
    logic [NUM_ZONES*FIELD_W-1:0] limits;
    logic [NUM_ZONES-1:0]         irq_en;
    logic                         restart;
    logic                         clear_all;
    logic [NUM_ZONES-1:0]         ack_mask;
    logic [NUM_ZONES-1:0]         status;
    logic [NUM_ZONES*CNT_W-1:0]   zone_max;
    logic                         boundary;
    logic [CNT_W-1:0]             win_count;

    bwz_regs #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status    (status),
        .zone_max  (zone_max),
        .ctrl_en   (ctrl_en),
        .win_len   (win_len),
        .thr_lo    (thr_lo),
        .thr_mid   (thr_mid),
        .thr_hi    (thr_hi),
        .actions   (actions),
        .limits    (limits),
        .irq_en    (irq_en),
        .restart   (restart),
        .clear_all (clear_all),
        .ack_mask  (ack_mask)
    );

    bwz_window #(
        .WIN_W(WIN_W), .BYTES_W(BYTES_W), .CNT_W(CNT_W), .UNIT_SH(UNIT_SH)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctrl_en),
        .ref_tick   (ref_tick),
        .win_len    (win_len),
        .xfer_valid (xfer_valid),
        .xfer_bytes (xfer_bytes),
        .restart    (restart),
        .boundary   (boundary),
        .win_count  (win_count)
    );

    bwz_zone_engine #(.CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .win_count (win_count),
        .thr_lo    (thr_lo),
        .thr_mid   (thr_mid),
        .thr_hi    (thr_hi),
        .actions   (actions),
        .limits    (limits),
        .clear_all (clear_all),
        .ack_mask  (ack_mask),
        .status    (status),
        .zone_max  (zone_max)
    );

    assign irq = |(status & irq_en);
endmodule

// File: rtl/bwz_checks.sv
// Property checker for the zoned bandwidth monitor, bound to the top.
module bwz_checks
    import bwz_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         boundary,
    input logic                         ctrl_en,
    input logic                         clear_all,
    input logic [NUM_ZONES-1:0]         status,
    input logic [NUM_ZONES-1:0]         ack_mask,
    input logic [NUM_ZONES*FIELD_W-1:0] limits,
    input logic [NUM_ZONES*CNT_W-1:0]   zone_max
);
    AST_CLOSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> ctrl_en); // R9

    AST_IDLE_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && ack_mask == '0) |=> $stable(status)); // R9

    for (genvar t = 0; t < NUM_ZONES; t++) begin : g_chk
        AST_STATUS_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[t]) |-> $past(boundary)); // R5

        AST_LIMIT_FF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[t]) |-> ($past(limits[t*FIELD_W +: FIELD_W]) != 8'hFF)); // R5

        AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_mask[t] && !boundary) |=> !status[t]); // R7

        AST_MAX_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
            !clear_all |=> (zone_max[t*CNT_W +: CNT_W] >= $past(zone_max[t*CNT_W +: CNT_W]))); // R6
    end
endmodule

bind bw_zone_monitor bwz_checks #(.CNT_W(CNT_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .ctrl_en   (ctrl_en),
    .clear_all (clear_all),
    .status    (status),
    .ack_mask  (ack_mask),
    .limits    (limits),
    .zone_max  (zone_max)
);

// File: tb/tb_bw_zone_monitor.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks with hand-computed expectations.
module tb_bw_zone_monitor;
    localparam int WIN_W = 24;
    localparam int BYTES_W = 16;
    localparam int UNIT = 64;
    localparam int SH = 6;
    localparam int CNT_W = 12;
    localparam longint ACC_MAX = (longint'(4096) << SH) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic xfer_valid = 1'b0;
    logic [BYTES_W-1:0] xfer_bytes = '0;
    logic reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bw_zone_monitor #(.WIN_W(WIN_W), .BYTES_W(BYTES_W), .UNIT_BYTES(UNIT), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .xfer_valid(xfer_valid),
        .xfer_bytes(xfer_bytes), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    bit          m_en;
    longint      m_win, m_tc, m_acc;
    int          m_lo, m_mid, m_hi;
    bit [31:0]   m_act, m_lim;
    bit [3:0]    m_ien, m_st;
    int          m_hit[4];
    int          m_max[4];

    always @(posedge clk) begin
        bit clrw, clra, tk, bnd;
        longint add, cnt;
        int z, code, lim;
        bit [3:0] nst;
        if (!rst_n) begin
            m_en = 0; m_win = 0; m_tc = 0; m_acc = 0;
            m_lo = 0; m_mid = 0; m_hi = 0; m_act = 0; m_lim = 32'hFFFF_FFFF;
            m_ien = 0; m_st = 0;
            for (int i = 0; i < 4; i++) begin m_hit[i] = 0; m_max[i] = 0; end
        end else begin
            clrw = reg_we && reg_addr == 8'h04 && (reg_wdata[0] || reg_wdata[1]);
            clra = reg_we && reg_addr == 8'h04 && reg_wdata[1];
            tk   = m_en && ref_tick;
            bnd  = tk && m_win != 0 && (m_tc + 1 >= m_win) && !clrw;
            add  = (m_en && xfer_valid) ? longint'(xfer_bytes) : 0;
            cnt  = m_acc >> SH;
            if (cnt < m_lo) z = 0;
            else if (cnt < m_mid) z = 1;
            else if (cnt < m_hi) z = 2;
            else z = 3;
            nst = m_st;
            if (reg_we && reg_addr == 8'h24) nst = nst & ~reg_wdata[3:0];
            if (bnd) begin
                for (int t = 0; t < 4; t++) begin
                    code = int'((m_act >> (8*z + 2*t)) & 32'd3);
                    if (code == 2) begin
                        if (m_hit[t] < 255) m_hit[t]++;
                        lim = int'((m_lim >> (8*t)) & 32'hFF);
                        if (lim != 255 && m_hit[t] >= lim) nst[t] = 1'b1;
                    end else if (code == 1) begin
                        m_hit[t] = 0;
                    end
                end
                if (int'(cnt) > m_max[z]) m_max[z] = int'(cnt);
            end
            if (clra) for (int i = 0; i < 4; i++) begin m_hit[i] = 0; m_max[i] = 0; end
            if (clrw) begin m_tc = 0; m_acc = 0; end
            else if (bnd) begin m_tc = 0; m_acc = add; end
            else begin
                if (tk) m_tc++;
                m_acc = (m_acc + add > ACC_MAX) ? ACC_MAX : m_acc + add;
            end
            m_st = nst;
            if (reg_we) begin
                case (reg_addr)
                    8'h00: m_en  = reg_wdata[0];
                    8'h08: m_win = longint'(reg_wdata[23:0]);
                    8'h0C: m_lo  = int'(reg_wdata[11:0]);
                    8'h10: m_mid = int'(reg_wdata[11:0]);
                    8'h14: m_hi  = int'(reg_wdata[11:0]);
                    8'h18: m_act = reg_wdata;
                    8'h1C: m_lim = reg_wdata;
                    8'h28: m_ien = reg_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'd0, m_en};
            8'h08: return 32'(m_win);
            8'h0C: return 32'(m_lo);
            8'h10: return 32'(m_mid);
            8'h14: return 32'(m_hi);
            8'h18: return m_act;
            8'h1C: return m_lim;
            8'h20: return {28'd0, m_st};
            8'h28: return {28'd0, m_ien};
            8'h30: return 32'(m_max[0]);
            8'h34: return 32'(m_max[1]);
            8'h38: return 32'(m_max[2]);
            8'h3C: return 32'(m_max[3]);
            default: return 32'd0;
        endcase
    endfunction

    // Cycle compare against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks += 2;
            if (reg_rdata !== model_read(reg_addr)) begin
                fails++;
                $display("FAIL R11 cycle read addr=0x%0h actual=0x%0h expected=0x%0h",
                         reg_addr, reg_rdata, model_read(reg_addr));
            end
            if (irq !== (|(m_st & m_ien))) begin
                fails++;
                $display("FAIL R7 cycle irq actual=%0b expected=%0b", irq, |(m_st & m_ien));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic go();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        go();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        go();
    endtask

    task automatic irqchk(input string tag, input logic exp);
        @(negedge clk);
        chk(tag, {31'd0, irq}, {31'd0, exp});
        go();
    endtask

    task automatic xfer(input int nbytes);
        xfer_valid = 1'b1; xfer_bytes = BYTES_W'(nbytes);
        go();
        xfer_valid = 1'b0; xfer_bytes = '0;
    endtask

    task automatic ticks(input int n);
        ref_tick = 1'b1;
        repeat (n) go();
        ref_tick = 1'b0;
    endtask

    task automatic win(input int units);
        if (units > 0) xfer(units * UNIT);
        ticks(4);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired actual=timeout expected=finish");
            finish_run();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R11 reset state and write-only reads
        rchk("R11 limit reset", 8'h1C, 32'hFFFF_FFFF);
        rchk("R11 status reset", 8'h20, 32'h0);
        rchk("R11 ctrl reset", 8'h00, 32'h0);
        rchk("R11 restart reads zero", 8'h04, 32'h0);
        rchk("R11 ack reads zero", 8'h24, 32'h0);
        irqchk("R7 irq reset", 1'b0);

        // configuration
        wr(8'h08, 32'd4);
        wr(8'h0C, 32'd2);
        wr(8'h10, 32'd5);
        wr(8'h14, 32'd10);
        wr(8'h18, 32'h9525_0901);
        wr(8'h1C, 32'h01FF_02FF);
        wr(8'h28, 32'hA);
        wr(8'h00, 32'h1);

        // R1 close lands on the fourth tick
        xfer(12 * UNIT);
        ticks(3);
        rchk("R1 no close after 3 ticks", 8'h20, 32'h0);
        ticks(1);
        rchk("R1 close on 4th tick", 8'h20, 32'h8);
        wr(8'h24, 32'hF);

        // R5 zone 1 needs two hits
        win(3);
        rchk("R6 zone1 max", 8'h34, 32'd3);
        rchk("R5 one hit below limit", 8'h20, 32'h0);
        win(4);
        rchk("R5 limit reached", 8'h20, 32'h2);
        irqchk("R7 irq enabled bit", 1'b1);
        rchk("R6 zone1 max grows", 8'h34, 32'd4);
        wr(8'h24, 32'h2);
        rchk("R7 ack clears", 8'h20, 32'h0);
        irqchk("R7 irq drops", 1'b0);

        // R3 zone 3 and R5 limit 0xFF suppression
        win(12);
        rchk("R3 zone3 status", 8'h20, 32'h8);
        rchk("R6 zone3 max", 8'h3C, 32'd12);
        win(7);
        rchk("R5 limit FF silent", 8'h20, 32'h8);
        rchk("R6 zone2 max", 8'h38, 32'd7);
        win(2);
        rchk("R6 max does not fall", 8'h34, 32'd4);

        // R8 clear-all, then R3 equality at thresholds
        wr(8'h04, 32'h2);
        rchk("R8 clear-all zeroes max", 8'h3C, 32'h0);
        win(2);
        rchk("R3 count equal to low is zone1", 8'h34, 32'd2);
        wr(8'h24, 32'hF);
        win(10);
        rchk("R3 count equal to high is zone3", 8'h20, 32'h8);
        rchk("R3 zone3 max at high", 8'h3C, 32'd10);

        // R2 saturation and unit flooring
        repeat (5) xfer(65472);
        ticks(4);
        rchk("R2 count saturates", 8'h3C, 32'hFFF);
        xfer(150);
        xfer(150);
        ticks(4);
        rchk("R2 floor division", 8'h34, 32'd4);

        // R8 window restart drops earlier bytes
        wr(8'h24, 32'hF);
        wr(8'h04, 32'h2);
        xfer(12 * UNIT);
        wr(8'h04, 32'h1);
        win(3);
        rchk("R8 restart status", 8'h20, 32'h0);
        rchk("R8 restart count", 8'h34, 32'd3);

        // R10 transfer on the closing cycle belongs to the next window
        wr(8'h04, 32'h2);
        xfer(UNIT);
        ref_tick = 1'b1;
        repeat (3) go();
        xfer_valid = 1'b1; xfer_bytes = BYTES_W'(5 * UNIT);
        go();
        xfer_valid = 1'b0; xfer_bytes = '0; ref_tick = 1'b0;
        ticks(4);
        rchk("R10 closing window count", 8'h30, 32'd1);
        rchk("R10 next window count", 8'h38, 32'd5);

        // R9 disabled monitor ignores traffic and ticks
        wr(8'h24, 32'hF);
        wr(8'h04, 32'h2);
        wr(8'h00, 32'h0);
        xfer(12 * UNIT);
        ticks(8);
        rchk("R9 no status while disabled", 8'h20, 32'h0);
        wr(8'h00, 32'h1);
        win(3);
        rchk("R9 disabled bytes dropped", 8'h20, 32'h0);
        rchk("R9 count after re-enable", 8'h34, 32'd3);

        // R7 status latches with enable off
        wr(8'h1C, 32'h0101_02FF);
        win(7);
        rchk("R7 masked status latches", 8'h20, 32'h4);
        irqchk("R7 masked bit keeps irq low", 1'b0);

        // R4 custom action: zone1 bumps zone0 only
        wr(8'h24, 32'hF);
        wr(8'h18, 32'h9525_0201);
        wr(8'h1C, 32'h0101_0201);
        win(3);
        rchk("R4 cross-zone bump", 8'h20, 32'h1);

        // R1 length zero never closes
        wr(8'h24, 32'hF);
        wr(8'h08, 32'h0);
        xfer(12 * UNIT);
        ticks(10);
        rchk("R1 zero length no close", 8'h20, 32'h0);
        wr(8'h08, 32'd4);
        ticks(4);
        rchk("R1 close after length set", 8'h20, 32'h8);

        finish_run();
    end
endmodule